// File: doc/BRIEF.md
# Grouped Interrupt Status Aggregator

This block folds a wide vector of per-pin interrupt requests into a compact summary, one bit per group of four neighbouring pins, and drives a single parent interrupt line toward the system interrupt controller. With the default 184 request inputs the summary holds 46 bits. Software reads it as two 32-bit words to find which groups need service, then visits the pins of those groups. Per-pin detection, such as edge or level sensing, is done upstream. This block sees only the resulting request levels.

The parent line is latched. Once raised, it stays high until software writes the end-of-interrupt (EOI) bit in the master control word. The line then drops for exactly one cycle, which gives the parent controller a fresh edge, and rises again if any request is still present. Requests that arrive while the line is high do not disturb it. Pins are grouped in banks that start at pin indices 0, 64 and 128, and the group map runs straight across those boundaries.

Top module: `gia_irq_aggregator`

## Requirements
- R1: Summary bit n is high exactly when at least one of request inputs 4n, 4n+1, 4n+2 or 4n+3 is high, for n = 0 to 45. Grouping is unaffected by the bank boundaries at pins 64 and 128.
- R2: A read at word address 0 returns summary bits 31..0 in data bits 31..0. A read at word address 1 returns summary bits 45..32 in data bits 13..0, with data bits 31..14 reading 0. Read data is combinational in the same cycle as the address.
- R3: After reset `irq_out` is 0. While the line is idle, a request seen at a clock edge raises `irq_out` after that edge. `irq_out` never rises unless some request was present at the preceding edge.
- R4: Once high, `irq_out` stays high on every following cycle until an EOI is written, even if all requests drop.
- R5: An EOI is a write to word address 2 with data bit 29 set. An EOI taken while `irq_out` is high drives `irq_out` low for exactly one cycle. At the next edge the line rises again if any request is present then, and otherwise stays low.
- R6: The master word at address 2 always reads as 0, including the EOI bit just after it is written.
- R7: A write to address 2 with bit 29 clear, a write to any other address, and an EOI written while the line is idle or in its one-cycle gap all leave `irq_out` unchanged.
- R8: Reads have no side effects, and address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_req | input | 184 | Per-pin interrupt request levels |
| reg_addr | input | 2 | Word address of the register port |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| irq_out | output | 1 | Parent interrupt line |

## Verification
Two functions can fall in the same cycle: the EOI write that re-arms the line, and a change in the request vector. The bench raises a new request in the very cycle the EOI is written, and it also withdraws the last request during the one-cycle gap. It then judges the gap cycle and the following cycle against the rule that only the requests present at the gap's closing edge decide whether the line rises again. A further case writes an EOI while the line is already in its gap and confirms that this write neither lengthens the gap nor skips it.

// File: rtl/gia_pkg.sv
package gia_pkg;
  // Register word addresses; software depends on these.
  localparam int unsigned WADDR_SUM_LO = 0;
  localparam int unsigned WADDR_SUM_HI = 1;
  localparam int unsigned WADDR_MASTER = 2;

  // Parent line states.
  typedef enum logic [1:0] {
    LINE_IDLE = 2'd0,
    LINE_HELD = 2'd1,
    LINE_GAP  = 2'd2
  } line_state_t;
endpackage

// File: rtl/gia_group_reduce.sv
module gia_group_reduce #(
  parameter int unsigned NUM_PINS     = 184,
  parameter int unsigned PINS_PER_GRP = 4,
  parameter int unsigned NUM_GRPS     = (NUM_PINS + PINS_PER_GRP - 1) / PINS_PER_GRP
) (
  input  logic [NUM_PINS-1:0] pin_req,
  output logic [NUM_GRPS-1:0] summary
);
  localparam int unsigned PAD_W = NUM_GRPS * PINS_PER_GRP;

  logic [PAD_W-1:0] padded;
  assign padded = PAD_W'(pin_req);

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
    assign summary[g] = |padded[g*PINS_PER_GRP +: PINS_PER_GRP];
  end
endmodule

// File: rtl/gia_status_view.sv
module gia_status_view
  import gia_pkg::*;
#(
  parameter int unsigned NUM_GRPS = 46,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic [NUM_GRPS-1:0] summary,
  input  logic [ADDR_W-1:0]   reg_addr,
  output logic [DATA_W-1:0]   reg_rdata
);
  localparam int unsigned SUM_W = 2 * DATA_W;

  // Zero-extend the summary to two full words.
  function automatic logic [SUM_W-1:0] widen(input logic [NUM_GRPS-1:0] s);
    return SUM_W'(s);
  endfunction

  logic [SUM_W-1:0] sum_wide;
  assign sum_wide = widen(summary);

  always_comb begin
    case (int'(reg_addr))
      WADDR_SUM_LO: reg_rdata = sum_wide[DATA_W-1:0];
      WADDR_SUM_HI: reg_rdata = sum_wide[SUM_W-1:DATA_W];
      default:      reg_rdata = '0;  // master word and unused addresses read 0
    endcase
  end
endmodule

// File: rtl/gia_eoi_ctrl.sv
module gia_eoi_ctrl
  import gia_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic any_req,
  input  logic eoi_fire,
  output logic irq,
  output logic in_gap
);
  line_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      LINE_IDLE: if (any_req)  state_d = LINE_HELD;
      LINE_HELD: if (eoi_fire) state_d = LINE_GAP;
      LINE_GAP:  state_d = any_req ? LINE_HELD : LINE_IDLE;
      default:   state_d = LINE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= LINE_IDLE;
    else        state_q <= state_d;
  end

  assign irq    = (state_q == LINE_HELD);
  assign in_gap = (state_q == LINE_GAP);
endmodule

// File: rtl/gia_irq_aggregator.sv
module gia_irq_aggregator
  import gia_pkg::*;
#(
  parameter int unsigned NUM_PINS     = 184,
  parameter int unsigned PINS_PER_GRP = 4,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned ADDR_W       = 2,
  parameter int unsigned EOI_BIT      = 29
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_req,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq_out
);
  localparam int unsigned NUM_GRPS = (NUM_PINS + PINS_PER_GRP - 1) / PINS_PER_GRP;

  logic [NUM_GRPS-1:0] summary;
  logic                any_req;
  logic                eoi_fire;
  logic                in_gap;
  logic                unused_wdata;

  gia_group_reduce #(
    .NUM_PINS(NUM_PINS), .PINS_PER_GRP(PINS_PER_GRP), .NUM_GRPS(NUM_GRPS)
  ) u_reduce (
    .pin_req(pin_req), .summary(summary)
  );

  gia_status_view #(
    .NUM_GRPS(NUM_GRPS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_view (
    .summary(summary), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
  );

  // Named internal events for the checker.
  assign any_req      = |summary;
  assign eoi_fire     = reg_wr && (int'(reg_addr) == WADDR_MASTER) && reg_wdata[EOI_BIT];
  assign unused_wdata = ^reg_wdata;

  gia_eoi_ctrl u_line (
    .clk(clk), .rst_n(rst_n), .any_req(any_req), .eoi_fire(eoi_fire),
    .irq(irq_out), .in_gap(in_gap)
  );
endmodule

// File: rtl/gia_irq_checker.sv
module gia_irq_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_out,
  input logic              any_req,
  input logic              eoi_fire,
  input logic              in_gap,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata
);
  // R4: held line stays high without EOI
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !eoi_fire) |=> irq_out);
  // R5: EOI on a high line opens a one-cycle gap
  p_gap_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && eoi_fire) |=> (!irq_out && in_gap));
  // R5: gap lasts one cycle and is closed by pending requests
  p_gap_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |=> (!in_gap && (irq_out == $past(any_req))));
  // R3: idle line rises on a request
  p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_out && !in_gap && any_req) |=> irq_out);
  // R3: no rise without a request
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(any_req));
  // R6: master word reads zero
  p_master_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(2)) |-> (reg_rdata == '0));
  // R2: high summary word padding reads zero
  p_hi_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(1)) |-> (reg_rdata[DATA_W-1:14] == '0));
endmodule

bind gia_irq_aggregator gia_irq_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .any_req(any_req),
  .eoi_fire(eoi_fire), .in_gap(in_gap), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/tb_gia_irq_aggregator.sv
module tb_gia_irq_aggregator;
  localparam int NP = 184;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin_req = '0;
  logic [1:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gia_irq_aggregator dut (
    .clk(clk), .rst_n(rst_n), .pin_req(pin_req), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // Bench model: scatter each set pin into its group.
  function automatic logic [63:0] model_sum(input logic [NP-1:0] p);
    logic [63:0] s = '0;
    for (int i = 0; i < NP; i++) if (p[i]) s[i/4] = 1'b1;
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic settle_idle();
    pin_req = '0;
    if (irq_out) write_reg(2'd2, 32'h2000_0000);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R3 reset irq", {31'd0, irq_out}, 32'd0);
  endtask

  task automatic t_summary(input logic [NP-1:0] p, input string tag);
    logic [31:0] d;
    logic [63:0] e;
    pin_req = p;
    e = model_sum(p);
    read_reg(2'd0, d); check({"R1 R2 low ", tag}, d, e[31:0]);
    read_reg(2'd1, d); check({"R1 R2 high ", tag}, d, e[63:32]);
  endtask

  task automatic t_summaries();
    logic [NP-1:0] p;
    p = '0; p[0] = 1'b1; t_summary(p, "pin0");
    p = '0; p[183] = 1'b1; t_summary(p, "pin183");
    p = '0; p[63] = 1'b1; p[64] = 1'b1; t_summary(p, "bank64");
    p = '0; p[127] = 1'b1; p[128] = 1'b1; t_summary(p, "bank128");
    p = '0; p[6] = 1'b1; p[101] = 1'b1; p[150] = 1'b1; t_summary(p, "mixed");
    p = '1; t_summary(p, "all");
    settle_idle();
  endtask

  task automatic t_rise_hold();
    pin_req[10] = 1'b1; #1;
    check("R3 not before edge", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R3 rise", {31'd0, irq_out}, 32'd1);
    pin_req = '0;
    repeat (5) @(negedge clk);
    check("R4 hold after drop", {31'd0, irq_out}, 32'd1);
    write_reg(2'd2, 32'h0000_0001);
    check("R7 wrong bit", {31'd0, irq_out}, 32'd1);
    write_reg(2'd1, 32'hFFFF_FFFF);
    check("R7 wrong addr", {31'd0, irq_out}, 32'd1);
    write_reg(2'd2, 32'h2000_0000);
    check("R5 gap low", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R5 no rearm when empty", {31'd0, irq_out}, 32'd0);
    repeat (3) @(negedge clk);
    check("R5 stays idle", {31'd0, irq_out}, 32'd0);
  endtask

  task automatic t_rearm();
    logic [31:0] d;
    pin_req[77] = 1'b1;
    @(negedge clk);
    write_reg(2'd2, 32'hFFFF_FFFF);
    check("R5 gap with pending", {31'd0, irq_out}, 32'd0);
    read_reg(2'd2, d); check("R6 master reads zero", d, 32'd0);
    @(negedge clk);
    check("R5 reassert", {31'd0, irq_out}, 32'd1);
    settle_idle();
  endtask

  task automatic t_idle_eoi();
    logic [31:0] d;
    write_reg(2'd2, 32'h2000_0000);
    check("R7 eoi idle", {31'd0, irq_out}, 32'd0);
    read_reg(2'd3, d); check("R8 addr3 zero", d, 32'd0);
    pin_req[180] = 1'b1;
    read_reg(2'd1, d); read_reg(2'd0, d); read_reg(2'd1, d);
    check("R8 repeat read", d, 32'h0000_2000);
    @(negedge clk);
    check("R8 irq after reads", {31'd0, irq_out}, 32'd1);
    settle_idle();
  endtask

  task automatic t_same_cycle();
    pin_req[3] = 1'b1;
    @(negedge clk);
    pin_req = '0;
    pin_req[90] = 1'b1;             // new request in the EOI cycle
    write_reg(2'd2, 32'h2000_0000);
    check("R5 same-cycle gap", {31'd0, irq_out}, 32'd0);
    pin_req = '0;                   // withdrawn during the gap
    write_reg(2'd2, 32'h2000_0000); // EOI inside the gap
    check("R7 eoi in gap", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R5 idle after withdraw", {31'd0, irq_out}, 32'd0);
    pin_req[90] = 1'b1;
    @(negedge clk);
    write_reg(2'd2, 32'h2000_0000);
    @(negedge clk);
    check("R5 same-cycle reassert", {31'd0, irq_out}, 32'd1);
    settle_idle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_summaries();
    t_rise_hold();
    t_rearm();
    t_idle_eoi();
    t_same_cycle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule